// File: doc/BRIEF.md
# Held-Low Wake Qualifier

This block sits in the always-on domain and runs from a slow oscillator clock with a nominal period of 1 µs. It decides whether a low level on a level-sensitive interrupt line should bring the system out of power-down. It also decides whether that wake-up should raise an interrupt. While power-down is indicated and the line's interrupt is enabled, the line is sampled on each clock edge. Two low samples in a row qualify a wake-up, and a one-cycle wake pulse is issued.

After the wake pulse, the block counts a programmable start-up time. When the count completes, it looks at the line once more. If the line is still low and still enabled, interrupt-valid is raised in that completion cycle. If the level has already gone, the wake-up still happened, but no interrupt is raised. The block then waits in a finished state until power-down is entered again, shown by a rising edge on the power-down indication, and this returns it to idle.

Top module: `lwq_wake_qual`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `wake_pulse` and `irq_valid` are 0.
- R2: If `line_lvl` is 0 with `irq_en`=1 and `pwr_down`=1 at two consecutive rising edges, `wake_pulse` is 1 for exactly the one cycle after the second edge.
- R3: A single low sample followed by a high sample (`line_lvl`=1) resets qualification, and no wake pulse follows.
- R4: No wake-up is qualified while `irq_en`=0 or `pwr_down`=0.
- R5: With start-up length L (sampled in the wake-pulse cycle), start-up completes in the cycle L+1 cycles after the wake-pulse cycle. L=0 completes in the cycle right after the wake pulse.
- R6: `irq_valid` is 1 in the completion cycle only if `line_lvl` is 0 in that cycle. If the line is high then, the wake pulse has still been issued and `irq_valid` stays 0.
- R7: `irq_valid` is never high for more than one cycle per wake-up, and is never high outside a completion cycle.
- R8: After completion, no further wake pulse occurs until `pwr_down` shows a rising edge, which returns the block to idle so that it can qualify again.
- R9: A rising edge of `pwr_down` (0 in the previous cycle, 1 now) in the completion cycle suppresses `irq_valid` and returns the block to idle.
- R10: `irq_valid` requires `irq_en`=1 in the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| line_lvl | input | 1 | Interrupt line level, active low |
| irq_en | input | 1 | Enable for the line's level interrupt |
| pwr_down | input | 1 | High while the system is in power-down |
| startup_len | input | CNT_W | Start-up time in oscillator cycles |
| wake_pulse | output | 1 | One-cycle wake request |
| irq_valid | output | 1 | Interrupt qualified, reported in the completion cycle |

## Verification
Two events can land in the same cycle: the end of the start-up count, and the re-entry into power-down shown by a rising edge on the power-down input. The bench provokes this by dropping `pwr_down` in the cycle before completion and raising it in the completion cycle. It then judges that no interrupt is raised and that the block re-qualifies from idle. A second same-cycle case is the line being released exactly in the completion cycle, compared with being released one cycle later. The reference model predicts both outcomes on every clock.

// File: rtl/lwq_pkg.sv
package lwq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SAMPLE1 = 3'd1,
        ST_QUAL    = 3'd2,
        ST_STARTUP = 3'd3,
        ST_DONE    = 3'd4
    } lwq_state_e;

    // Per-cycle view of the inputs, produced by the sampler.
    typedef struct packed {
        logic line_low;   // line currently low
        logic arm_ok;     // low, enabled and in power-down
        logic irq_ok;     // low and enabled
        logic pd_rise;    // power-down re-entered this cycle
    } lwq_obs_t;

    function automatic logic lwq_arm(input logic low, input logic en, input logic pd);
        return low & en & pd;
    endfunction

endpackage

// File: rtl/lwq_sampler.sv
module lwq_sampler
    import lwq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     line_lvl,
    input  logic     irq_en,
    input  logic     pwr_down,
    output lwq_obs_t obs
);
    logic pd_q;

    always_ff @(posedge clk) begin
        if (rst) pd_q <= 1'b0;
        else     pd_q <= pwr_down;
    end

    always_comb begin
        obs.line_low = ~line_lvl;
        obs.arm_ok   = lwq_arm(~line_lvl, irq_en, pwr_down);
        obs.irq_ok   = ~line_lvl & irq_en;
        obs.pd_rise  = pwr_down & ~pd_q;
    end
endmodule

// File: rtl/lwq_startup_cnt.sv
module lwq_startup_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (dec && cnt != '0) cnt <= cnt - ONE;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/lwq_fsm.sv
module lwq_fsm
    import lwq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lwq_obs_t   obs,
    input  logic       cnt_zero,
    output lwq_state_e state,
    output logic       cnt_load,
    output logic       cnt_dec,
    output logic       wake_pulse,
    output logic       irq_valid
);
    lwq_state_e nxt;

    always_comb begin
        nxt      = state;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state)
            ST_IDLE:    if (obs.arm_ok) nxt = ST_SAMPLE1;
            ST_SAMPLE1: nxt = obs.arm_ok ? ST_QUAL : ST_IDLE;
            ST_QUAL: begin
                nxt      = ST_STARTUP;
                cnt_load = 1'b1;
            end
            ST_STARTUP: begin
                if (cnt_zero) nxt = ST_DONE;
                else          cnt_dec = 1'b1;
            end
            ST_DONE:    nxt = ST_DONE;
            default:    nxt = ST_IDLE;
        endcase
        // re-entry into power-down overrides everything outside idle
        if (obs.pd_rise && state != ST_IDLE) begin
            nxt      = ST_IDLE;
            cnt_load = 1'b0;
            cnt_dec  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign wake_pulse = (state == ST_QUAL);
    assign irq_valid  = (state == ST_STARTUP) && cnt_zero && obs.irq_ok && !obs.pd_rise;
endmodule

// File: rtl/lwq_wake_qual.sv
module lwq_wake_qual
    import lwq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_lvl,
    input  logic             irq_en,
    input  logic             pwr_down,
    input  logic [CNT_W-1:0] startup_len,
    output logic             wake_pulse,
    output logic             irq_valid
);
    lwq_obs_t   obs;
    lwq_state_e state;
    logic       cnt_load;
    logic       cnt_dec;
    logic       cnt_zero;

    lwq_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .line_lvl (line_lvl),
        .irq_en   (irq_en),
        .pwr_down (pwr_down),
        .obs      (obs)
    );

    lwq_startup_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .dec      (cnt_dec),
        .load_val (startup_len),
        .zero     (cnt_zero)
    );

    lwq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .obs        (obs),
        .cnt_zero   (cnt_zero),
        .state      (state),
        .cnt_load   (cnt_load),
        .cnt_dec    (cnt_dec),
        .wake_pulse (wake_pulse),
        .irq_valid  (irq_valid)
    );
endmodule

// File: rtl/lwq_wake_qual_chk.sv
module lwq_wake_qual_chk (
    input logic clk,
    input logic rst,
    input logic line_lvl,
    input logic irq_en,
    input logic pwr_down,
    input logic wake_pulse,
    input logic irq_valid
);
    // R2
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    // R2
    wake_two_low_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (!$past(line_lvl, 1) && !$past(line_lvl, 2)));

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |=> !irq_valid);

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (!line_lvl && irq_en));

    // R9
    irq_reentry_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> !(pwr_down && !$past(pwr_down)));

    // R5
    wake_irq_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(wake_pulse && irq_valid));
endmodule

bind lwq_wake_qual lwq_wake_qual_chk u_chk (.*);

// File: tb/lwq_wake_qual_bench.sv
module lwq_wake_qual_bench;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             line_lvl = 1'b1;
    logic             irq_en = 1'b1;
    logic             pwr_down = 1'b0;
    logic [CNT_W-1:0] startup_len = '0;
    logic             wake_pulse;
    logic             irq_valid;

    int checks = 0;
    int errors = 0;
    int wakes  = 0;
    int irqs   = 0;
    bit finished = 0;

    // behavioural reference model
    int m_lows = 0;
    bit m_waking = 0;
    bit m_counting = 0;
    int m_remain = 0;
    bit m_done = 0;
    bit m_pd_prev = 0;

    always #5 clk = ~clk;

    lwq_wake_qual #(.CNT_W(CNT_W)) u_lwq_wake_qual (
        .clk         (clk),
        .rst         (rst),
        .line_lvl    (line_lvl),
        .irq_en      (irq_en),
        .pwr_down    (pwr_down),
        .startup_len (startup_len),
        .wake_pulse  (wake_pulse),
        .irq_valid   (irq_valid)
    );

    task automatic model_edge();
        bit rise;
        bit arm;
        rise = pwr_down && !m_pd_prev;
        arm  = !line_lvl && irq_en && pwr_down;
        if (rst) begin
            m_lows = 0; m_waking = 0; m_counting = 0; m_remain = 0; m_done = 0;
            m_pd_prev = 0;
            return;
        end
        if (rise && (m_lows > 0 || m_waking || m_counting || m_done)) begin
            m_lows = 0; m_waking = 0; m_counting = 0; m_done = 0;
        end else if (m_done) begin
            m_done = 1;
        end else if (m_counting) begin
            if (m_remain == 0) begin m_counting = 0; m_done = 1; end
            else m_remain = m_remain - 1;
        end else if (m_waking) begin
            m_waking = 0; m_counting = 1; m_remain = int'(startup_len);
        end else if (m_lows == 1) begin
            m_lows = 0;
            if (arm) m_waking = 1;
        end else if (arm) begin
            m_lows = 1;
        end
        m_pd_prev = pwr_down;
    endtask

    // compare outputs mid-cycle, then advance one clock
    task automatic cyc(input string tag);
        bit exp_w;
        bit exp_i;
        #3;
        exp_w = !rst && m_waking;
        exp_i = !rst && m_counting && m_remain == 0 && !line_lvl && irq_en
                && !(pwr_down && !m_pd_prev);
        checks++;
        if (wake_pulse !== exp_w || irq_valid !== exp_i) begin
            errors++;
            $display("FAIL %s t=%0t wake=%b irq=%b expected wake=%b irq=%b",
                     tag, $time, wake_pulse, irq_valid, exp_w, exp_i);
        end
        if (wake_pulse === 1'b1) wakes++;
        if (irq_valid === 1'b1) irqs++;
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic expect_counts(input string tag, input int ew, input int ei);
        checks++;
        if (wakes != ew || irqs != ei) begin
            errors++;
            $display("FAIL %s wakes=%0d irqs=%0d expected wakes=%0d irqs=%0d",
                     tag, wakes, irqs, ew, ei);
        end
        wakes = 0;
        irqs  = 0;
    endtask

    // leave power-down and enter it again: block back to idle
    task automatic reenter();
        line_lvl = 1'b1; pwr_down = 1'b0; irq_en = 1'b1;
        cyc("reenter");
        pwr_down = 1'b1;
        cyc("reenter");
        wakes = 0; irqs = 0;
    endtask

    initial begin
        @(posedge clk); #1;
        // R1 reset state
        for (int i = 0; i < 3; i++) cyc("R1");
        rst = 1'b0;
        cyc("R1");
        expect_counts("R1", 0, 0);

        // R2 / R5 held low, length 3: wake and interrupt
        reenter();
        startup_len = 8'd3; line_lvl = 1'b0;
        for (int i = 0; i < 10; i++) cyc("R2");
        expect_counts("R2", 1, 1);

        // R8 still low in finished state: no second wake
        for (int i = 0; i < 5; i++) cyc("R8");
        expect_counts("R8", 0, 0);
        reenter();
        line_lvl = 1'b0;
        for (int i = 0; i < 9; i++) cyc("R8");
        expect_counts("R8", 1, 1);

        // R3 single low sample
        reenter();
        line_lvl = 1'b0; cyc("R3");
        line_lvl = 1'b1;
        for (int i = 0; i < 5; i++) cyc("R3");
        expect_counts("R3", 0, 0);

        // R4 disabled or not in power-down
        reenter();
        irq_en = 1'b0; line_lvl = 1'b0;
        for (int i = 0; i < 6; i++) cyc("R4");
        expect_counts("R4", 0, 0);
        irq_en = 1'b1; pwr_down = 1'b0;
        for (int i = 0; i < 6; i++) cyc("R4");
        expect_counts("R4", 0, 0);

        // R6 released during start-up
        reenter();
        startup_len = 8'd4; line_lvl = 1'b0;
        for (int i = 0; i < 10; i++) begin
            line_lvl = (i < 3) ? 1'b0 : 1'b1;
            cyc("R6");
        end
        expect_counts("R6", 1, 0);

        // R6 released exactly in the completion cycle (cycle 5, L=2)
        reenter();
        startup_len = 8'd2;
        for (int i = 0; i < 8; i++) begin
            line_lvl = (i < 5) ? 1'b0 : 1'b1;
            cyc("R6");
        end
        expect_counts("R6", 1, 0);

        // R5 released one cycle after completion: interrupt raised
        reenter();
        startup_len = 8'd2;
        for (int i = 0; i < 8; i++) begin
            line_lvl = (i < 6) ? 1'b0 : 1'b1;
            cyc("R5");
        end
        expect_counts("R5", 1, 1);

        // R5 zero length start-up
        reenter();
        startup_len = 8'd0; line_lvl = 1'b0;
        for (int i = 0; i < 6; i++) cyc("R5");
        expect_counts("R5", 1, 1);

        // R9 re-entry coincides with completion (cycle 5, L=2)
        reenter();
        startup_len = 8'd2; line_lvl = 1'b0;
        for (int i = 0; i < 6; i++) begin
            pwr_down = (i == 4) ? 1'b0 : 1'b1;
            cyc("R9");
        end
        expect_counts("R9", 1, 0);
        for (int i = 0; i < 8; i++) cyc("R9");
        expect_counts("R9", 1, 1);

        // R10 enable dropped in completion cycle
        reenter();
        startup_len = 8'd2; line_lvl = 1'b0;
        for (int i = 0; i < 8; i++) begin
            irq_en = (i == 5) ? 1'b0 : 1'b1;
            cyc("R10");
        end
        expect_counts("R10", 1, 0);

        // R7 long start-up, single interrupt
        reenter();
        startup_len = 8'd20; line_lvl = 1'b0;
        for (int i = 0; i < 30; i++) cyc("R7");
        expect_counts("R7", 1, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule